// File: doc/BRIEF.md
# Two-Word Block Transfer Instruction Receiver

This block takes instruction words from a host computer over a valid/ready command channel. A word counts only in a cycle where the host asserts valid and the block asserts ready. Each accepted word is decoded. Most instructions are complete in one word: status request, master clear, terminate, memory protect, and a range of test-mode codes. The block announces each of these on a one-cycle decoded-operation output, together with the word's address field as an argument.

A read or a write takes two words. The first word names the operation and carries the begin address of the block. The second word carries the end address. Between the two words the block holds the pending command and shows it on an open-pair flag. When the end word arrives and the range is in order, the block raises a transfer request toward the downstream drum sequencer. It holds that request until the sequencer takes it.

Malformed input raises a one-cycle invalid-function pulse with a 4-bit cause code. A report flag tells the status-word logic which events need an interrupt status word.

Top module: `xfer_cmd_rx`

## Requirements
- R1: Word layout. The opcode sits in bits [WORD_W-1:WORD_W-4]. The address sits in bits [ADDR_W-1:0]. The bits between them are reserved. Opcodes are: 1 read begin, 2 write begin, 3 end address, 4 status request, 5 master clear, 6 terminate, 7 memory protect, 8 to 15 test. Opcode 0 is unassigned.
- R2: A word is taken only in a cycle with cmd_valid and cmd_ready both high. cmd_ready is low exactly while xfer_valid is high.
- R3: In idle, a read-begin or write-begin word sets pair_open on the next cycle and stores its address. No other output pulses.
- R4: While the pair is open, an end word with end address ≥ begin address has this effect on the next cycle: it clears pair_open and raises xfer_valid. xfer_write is 1 for a write. xfer_begin and xfer_end carry the two addresses. All of these hold unchanged until a cycle with xfer_ready high, after which xfer_valid drops.
- R5: An end word whose address is below the begin address gives inv_valid with inv_code 4. It issues no transfer and returns the block to idle.
- R6: In idle, a single-word instruction (opcodes 4 to 15) gives a one-cycle op_valid on the next cycle. op_kind equals the opcode and op_arg equals the address field.
- R7: Invalid words in idle give inv_valid on the next cycle with a cause code. Opcode 0 gives code 1. An end word gives code 2. A reserved field that is not zero gives code 5, whatever the opcode.
- R8: While the pair is open, any accepted word other than an end word or master clear raises inv_valid with code 3. It discards the pending command and returns to idle. The intruding word is not executed.
- R9: Master clear, from idle or with a pair open, clears pair_open on the next cycle. It gives op_valid with op_kind 5 and raises no invalid function.
- R10: status_rpt pulses in the same cycle as every inv_valid, as every rise of xfer_valid, and as op_valid for opcodes 5, 6 and 7. It stays low for status request (4) and for test codes (8 to 15).
- R11: After reset, op_valid, inv_valid, status_rpt, pair_open and xfer_valid are 0, and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host presents a word |
| cmd_word | input | WORD_W | Instruction word |
| cmd_ready | output | 1 | Block can take a word |
| op_valid | output | 1 | One-cycle pulse for a decoded single-word instruction |
| op_kind | output | 4 | Opcode of the decoded instruction |
| op_arg | output | ADDR_W | Address field of the decoded instruction |
| status_rpt | output | 1 | An interrupt status word is due for this event |
| inv_valid | output | 1 | One-cycle invalid-function pulse |
| inv_code | output | 4 | Cause of the invalid function |
| pair_open | output | 1 | First word of a read or write held, end word awaited |
| xfer_valid | output | 1 | Transfer request to the sequencer |
| xfer_ready | input | 1 | Sequencer takes the request |
| xfer_write | output | 1 | 1 for write, 0 for read |
| xfer_begin | output | ADDR_W | Begin address of the block |
| xfer_end | output | ADDR_W | End address of the block |

## Verification
The bench walks all sixteen opcodes from each of three starting states: idle, read pending and write pending.

Each of these faults shows up as a wrong pulse or a wrong code in one of those cells:
- executing the intruding word instead of aborting,
- letting master clear count as an intrusion,
- reporting status for a status request or test code.

Range edges are covered as well:
- equal begin and end addresses;
- an end one below the begin;
- zero and all-ones addresses.

A comparator that is off by one, or the wrong way round, fails these edge cases.

Words offered while a request waits must have no effect, and the request fields must stay stable; a design that accepts during that time shows it through pair_open or changed fields. Reserved-field and unqualified-valid words are covered too.

// File: rtl/xfer_cmd_pkg.sv
package xfer_cmd_pkg;
  localparam int OPC_W = 4;

  localparam logic [3:0] OPC_NONE  = 4'd0;
  localparam logic [3:0] OPC_RDBEG = 4'd1;
  localparam logic [3:0] OPC_WRBEG = 4'd2;
  localparam logic [3:0] OPC_ENDA  = 4'd3;
  localparam logic [3:0] OPC_STAT  = 4'd4;
  localparam logic [3:0] OPC_MCLR  = 4'd5;
  localparam logic [3:0] OPC_TERM  = 4'd6;
  localparam logic [3:0] OPC_PROT  = 4'd7;

  localparam logic [3:0] ERR_OPCODE = 4'd1;
  localparam logic [3:0] ERR_ORPHAN = 4'd2;
  localparam logic [3:0] ERR_BROKEN = 4'd3;
  localparam logic [3:0] ERR_RANGE  = 4'd4;
  localparam logic [3:0] ERR_RSVD   = 4'd5;

  typedef enum logic [2:0] {
    CLS_BEGIN,
    CLS_END,
    CLS_SINGLE,
    CLS_MCLR,
    CLS_BAD
  } word_cls_e;

  // Status request and test codes produce no status word.
  function automatic logic wants_report(input logic [3:0] opc);
    return !(opc == OPC_STAT || opc[3]);
  endfunction
endpackage

// File: rtl/xfer_cmd_decode.sv
module xfer_cmd_decode
  import xfer_cmd_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int ADDR_W = 18
) (
  input  logic [WORD_W-1:0] word,
  output logic [OPC_W-1:0]  opc,
  output logic [ADDR_W-1:0] addr,
  output word_cls_e         cls,
  output logic [3:0]        bad_code
);
  localparam int RSV_W = WORD_W - OPC_W - ADDR_W;

  logic rsv_bad;

  assign opc  = word[WORD_W-1 -: OPC_W];
  assign addr = word[ADDR_W-1:0];

  generate
    if (RSV_W > 0) begin : g_rsv
      assign rsv_bad = |word[ADDR_W +: RSV_W];
    end else begin : g_norsv
      assign rsv_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    bad_code = ERR_OPCODE;
    if (rsv_bad) begin
      cls      = CLS_BAD;
      bad_code = ERR_RSVD;
    end else begin
      unique case (opc)
        OPC_NONE:             cls = CLS_BAD;
        OPC_RDBEG, OPC_WRBEG: cls = CLS_BEGIN;
        OPC_ENDA:             cls = CLS_END;
        OPC_MCLR:             cls = CLS_MCLR;
        default:              cls = CLS_SINGLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_cmd_seq.sv
module xfer_cmd_seq
  import xfer_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  word_cls_e         cls,
  input  logic [OPC_W-1:0]  opc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        bad_code,
  input  logic              xfer_ready,
  output logic              op_valid,
  output logic [3:0]        op_kind,
  output logic [ADDR_W-1:0] op_arg,
  output logic              status_rpt,
  output logic              inv_valid,
  output logic [3:0]        inv_code,
  output logic              pair_open,
  output logic              xfer_valid,
  output logic              xfer_write,
  output logic [ADDR_W-1:0] xfer_begin,
  output logic [ADDR_W-1:0] xfer_end,
  output logic              evt_issue,
  output logic              evt_abort
);
  logic [ADDR_W-1:0] beg_q;
  logic              wr_q;

  function automatic logic range_in_order(input logic [ADDR_W-1:0] b,
                                          input logic [ADDR_W-1:0] e);
    return e >= b;
  endfunction

  assign evt_issue = accept && pair_open && cls == CLS_END && range_in_order(beg_q, addr);
  assign evt_abort = accept && pair_open && cls != CLS_END && cls != CLS_MCLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid   <= 1'b0;
      op_kind    <= '0;
      op_arg     <= '0;
      status_rpt <= 1'b0;
      inv_valid  <= 1'b0;
      inv_code   <= '0;
      pair_open  <= 1'b0;
      xfer_valid <= 1'b0;
      xfer_write <= 1'b0;
      xfer_begin <= '0;
      xfer_end   <= '0;
      beg_q      <= '0;
      wr_q       <= 1'b0;
    end else begin
      op_valid   <= 1'b0;
      inv_valid  <= 1'b0;
      status_rpt <= 1'b0;
      if (xfer_valid && xfer_ready) xfer_valid <= 1'b0;
      if (accept) begin
        if (cls == CLS_MCLR) begin
          pair_open  <= 1'b0;
          op_valid   <= 1'b1;
          op_kind    <= opc;
          op_arg     <= addr;
          status_rpt <= 1'b1;
        end else if (pair_open) begin
          pair_open  <= 1'b0;
          status_rpt <= 1'b1;
          if (evt_issue) begin
            xfer_valid <= 1'b1;
            xfer_write <= wr_q;
            xfer_begin <= beg_q;
            xfer_end   <= addr;
          end else begin
            inv_valid <= 1'b1;
            inv_code  <= (cls == CLS_END) ? ERR_RANGE : ERR_BROKEN;
          end
        end else begin
          unique case (cls)
            CLS_BEGIN: begin
              pair_open <= 1'b1;
              beg_q     <= addr;
              wr_q      <= (opc == OPC_WRBEG);
            end
            CLS_END: begin
              inv_valid  <= 1'b1;
              inv_code   <= ERR_ORPHAN;
              status_rpt <= 1'b1;
            end
            CLS_SINGLE: begin
              op_valid   <= 1'b1;
              op_kind    <= opc;
              op_arg     <= addr;
              status_rpt <= wants_report(opc);
            end
            default: begin
              inv_valid  <= 1'b1;
              inv_code   <= bad_code;
              status_rpt <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/xfer_cmd_rx.sv
module xfer_cmd_rx
  import xfer_cmd_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              cmd_ready,
  output logic              op_valid,
  output logic [3:0]        op_kind,
  output logic [ADDR_W-1:0] op_arg,
  output logic              status_rpt,
  output logic              inv_valid,
  output logic [3:0]        inv_code,
  output logic              pair_open,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic              xfer_write,
  output logic [ADDR_W-1:0] xfer_begin,
  output logic [ADDR_W-1:0] xfer_end
);
  logic [OPC_W-1:0]  dec_opc;
  logic [ADDR_W-1:0] dec_addr;
  word_cls_e         dec_cls;
  logic [3:0]        dec_bad;
  logic              evt_accept;
  logic              evt_issue;
  logic              evt_abort;

  assign cmd_ready  = !xfer_valid;
  assign evt_accept = cmd_valid && cmd_ready;

  xfer_cmd_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
    .word     (cmd_word),
    .opc      (dec_opc),
    .addr     (dec_addr),
    .cls      (dec_cls),
    .bad_code (dec_bad)
  );

  xfer_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (evt_accept),
    .cls        (dec_cls),
    .opc        (dec_opc),
    .addr       (dec_addr),
    .bad_code   (dec_bad),
    .xfer_ready (xfer_ready),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_arg     (op_arg),
    .status_rpt (status_rpt),
    .inv_valid  (inv_valid),
    .inv_code   (inv_code),
    .pair_open  (pair_open),
    .xfer_valid (xfer_valid),
    .xfer_write (xfer_write),
    .xfer_begin (xfer_begin),
    .xfer_end   (xfer_end),
    .evt_issue  (evt_issue),
    .evt_abort  (evt_abort)
  );
endmodule

// File: rtl/xfer_cmd_rx_chk.sv
module xfer_cmd_rx_chk #(
  parameter int WORD_W = 30,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [WORD_W-1:0] cmd_word,
  input logic              op_valid,
  input logic              inv_valid,
  input logic [3:0]        inv_code,
  input logic              status_rpt,
  input logic              pair_open,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_begin,
  input logic [ADDR_W-1:0] xfer_end,
  input logic              evt_accept,
  input logic              evt_abort
);
  // R2
  ready_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !cmd_ready);

  // R4
  request_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_begin) && $stable(xfer_end));

  // R5
  range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> xfer_end >= xfer_begin);

  // R8
  broken_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> inv_valid && inv_code == 4'd3 && !op_valid && !pair_open);

  // R9
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && cmd_word[WORD_W-1 -: 4] == 4'd5 && cmd_word[WORD_W-5:ADDR_W] == '0
    |=> !pair_open && !inv_valid);

  // R10
  report_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> status_rpt);

  // R6
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_valid, inv_valid, $rose(xfer_valid)}));
endmodule

bind xfer_cmd_rx xfer_cmd_rx_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_xfer_cmd_rx.sv
module test_xfer_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 30;
  localparam int ADDR_W = 18;
  localparam int RSV_W  = WORD_W - 4 - ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [WORD_W-1:0] cmd_word = '0;
  logic              cmd_ready;
  logic              op_valid;
  logic [3:0]        op_kind;
  logic [ADDR_W-1:0] op_arg;
  logic              status_rpt;
  logic              inv_valid;
  logic [3:0]        inv_code;
  logic              pair_open;
  logic              xfer_valid;
  logic              xfer_ready = 1'b0;
  logic              xfer_write;
  logic [ADDR_W-1:0] xfer_begin;
  logic [ADDR_W-1:0] xfer_end;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_cmd_rx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_xfer_cmd_rx (.*);

  function automatic logic [WORD_W-1:0] mk(input logic [3:0] opc, input logic [ADDR_W-1:0] a);
    return {opc, {RSV_W{1'b0}}, a};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Packed, masked view: opv kind inv code xv rpt open
  function automatic logic [63:0] view();
    return {51'd0, op_valid, op_valid ? op_kind : 4'd0, inv_valid,
            inv_valid ? inv_code : 4'd0, xfer_valid, status_rpt, pair_open};
  endfunction

  function automatic logic [63:0] pack(input logic opv, input logic [3:0] k, input logic iv,
                                       input logic [3:0] c, input logic xv, input logic r,
                                       input logic po);
    return {51'd0, opv, k, iv, c, xv, r, po};
  endfunction

  task automatic send(input logic [WORD_W-1:0] w);
    cmd_word = w;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    if (xfer_valid) begin
      xfer_ready = 1'b1;
      @(negedge clk);
      xfer_ready = 1'b0;
    end
    send(mk(4'd5, '0));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ba, ea;
    repeat (3) @(negedge clk);
    // R11
    check("R11 reset outputs", {59'd0, op_valid, inv_valid, status_rpt, pair_open, xfer_valid},
          64'd0);
    check("R11 ready after reset", {63'd0, cmd_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R6 R7 R8 R9 R10 sweep
    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 16; o++) begin
        logic [63:0] exp;
        logic [3:0] opc;
        opc = o[3:0];
        ba = ADDR_W'(100 + o * 7);
        ea = ba + ADDR_W'(s + 3);
        if (s != 0) begin
          send(mk(s == 1 ? 4'd1 : 4'd2, ba));
          check($sformatf("R3 open s%0d o%0d", s, o), view(), pack(0, 0, 0, 0, 0, 0, 1));
        end
        send(mk(opc, ea));
        if (s != 0) begin
          if (opc == 4'd5) exp = pack(1, 5, 0, 0, 0, 1, 0);
          else if (opc == 4'd3) exp = pack(0, 0, 0, 0, 1, 1, 0);
          else exp = pack(0, 0, 1, 3, 0, 1, 0);
        end else begin
          if (opc == 4'd0) exp = pack(0, 0, 1, 1, 0, 1, 0);
          else if (opc == 4'd1 || opc == 4'd2) exp = pack(0, 0, 0, 0, 0, 0, 1);
          else if (opc == 4'd3) exp = pack(0, 0, 1, 2, 0, 1, 0);
          else exp = pack(1, opc, 0, 0, 0, (opc >= 5 && opc <= 7), 0);
        end
        check($sformatf("R6/R7/R8/R9/R10 s%0d o%0d", s, o), view(), exp);
        if (op_valid) check($sformatf("R6 arg s%0d o%0d", s, o), 64'(op_arg), 64'(ea));
        if (s != 0 && opc == 4'd3)
          check($sformatf("R4 fields s%0d", s), {13'd0, xfer_write, xfer_begin, 14'd0, xfer_end},
                {13'd0, s == 2, ba, 14'd0, ea});
        settle();
      end
    end

    // R4 and R5 range edges
    for (int k = 0; k < 4; k++) begin
      logic ok;
      case (k)
        0: begin ba = 18'd500; ea = 18'd500; end
        1: begin ba = 18'd500; ea = 18'd499; end
        2: begin ba = '0; ea = '1; end
        default: begin ba = '1; ea = '0; end
      endcase
      ok = (ea >= ba);
      send(mk(4'd2, ba));
      send(mk(4'd3, ea));
      check($sformatf("R4/R5 range case %0d", k), view(),
            ok ? pack(0, 0, 0, 0, 1, 1, 0) : pack(0, 0, 1, 4, 0, 1, 0));
      if (ok) check($sformatf("R4 range fields %0d", k),
                    {14'd0, xfer_begin, 14'd0, xfer_end}, {14'd0, ba, 14'd0, ea});
      settle();
    end

    // R2 and R4 hold while request waits
    send(mk(4'd1, 18'd10));
    send(mk(4'd3, 18'd20));
    check("R2 ready low during request", {63'd0, cmd_ready}, 64'd0);
    cmd_word = mk(4'd2, 18'd77);
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 word ignored while busy", view(), pack(0, 0, 0, 0, 1, 0, 0));
    check("R4 fields held", {13'd0, xfer_write, xfer_begin, 14'd0, xfer_end},
          {13'd0, 1'b0, 18'd10, 14'd0, 18'd20});
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    check("R4 request drops after ready", {62'd0, xfer_valid, cmd_ready}, 64'd1);

    // R2 valid low has no effect
    cmd_word = mk(4'd1, 18'd5);
    repeat (2) @(negedge clk);
    check("R2 no valid no effect", view(), pack(0, 0, 0, 0, 0, 0, 0));

    // R7 reserved field
    send({4'd6, {RSV_W{1'b0}} | RSV_W'(1), 18'd3});
    check("R7 reserved bits code", view(), pack(0, 0, 1, 5, 0, 1, 0));
    send({4'd1, {RSV_W{1'b1}}, 18'd3});
    check("R7 reserved on begin word", view(), pack(0, 0, 1, 5, 0, 1, 0));
    @(negedge clk);
    check("R3 pulses last one cycle", view(), pack(0, 0, 0, 0, 0, 0, 0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule